// File: doc/BRIEF.md
# SPI NOR Flash Command Model

This block is a serial-flash slave built from synthesizable logic and backed by a small on-chip byte array. A host drives clock, select and data-in like an SPI master in mode 0. It reads the block's identification, streams data out, programs pages and erases sectors or the whole array, just as it would with a discrete NOR flash. The array size, page size, sector size and identification code are parameters. The defaults are 2048 bytes, 256-byte pages and 512-byte sectors, so that a whole device can be swept in simulation.

All SPI pins are brought into the system clock domain through two-flop synchronizers, so the SPI clock must stay low and high for at least four system clocks each. The decoder is a state machine with six states. S_IDLE waits for an opcode. S_ADDR collects address bytes. S_ID streams the identification. S_READ streams array data. S_PROG merges incoming data into the array. S_DISCARD swallows the rest of the frame. The transitions are listed below.

- S_IDLE→S_ID on the identification opcode.
- S_IDLE→S_ADDR on read, on sector erase, and on program when the write-enable latch is set.
- S_IDLE→S_DISCARD on program without the latch, and on any unknown opcode.
- S_IDLE→S_IDLE on single-byte commands.
- S_ADDR→S_READ, S_ADDR→S_PROG or S_ADDR→S_IDLE (sector erase) when the last address byte arrives.
- Any state→S_IDLE when select goes high.

Top module: `nor_flash_model`

## Requirements
- R1: Opcode 0x9F returns the 24-bit identification (default 0x20BA19) in the next three bytes, most significant byte first. Later bytes in the same frame read 0x00.
- R2: After power-on reset every array byte reads 0x00, addresses are 3 bytes long, and the write-enable latch is clear.
- R3: Opcode 0x03 followed by an address (most significant byte first) streams bytes from that address for as long as select stays low. The address advances by one per byte and wraps from the last array byte to byte 0. Address bits above the array size are ignored.
- R4: Opcode 0x06 sets the write-enable latch. Program and erase commands issued while the latch is clear change nothing.
- R5: Opcode 0x02 with an address writes each following data byte as old AND data. The byte offset wraps inside the current 256-byte page.
- R6: The latch clears when select rises after an accepted program, and at the moment an erase is launched.
- R7: Opcode 0xD8 with an address sets every byte of the sector holding that address to 0xFF within SECTOR_BYTES+2 cycles. Bytes outside that sector are untouched.
- R8: Opcode 0xC7 sets every array byte to 0xFF within MEM_BYTES+2 cycles.
- R9: Opcode 0xB7 makes later read, program and erase commands take 4 address bytes.
- R10: Opcode 0x99 that directly follows opcode 0x66 restores 3-byte addressing and clears the latch. A 0x99 preceded by any other opcode has no effect.
- R11: Single-byte commands (0x06, 0xB7, 0x66, 0x99, 0xC7) and sector erase return to opcode decoding, so several commands may share one select-low frame.
- R12: An unknown opcode makes the block ignore the rest of the frame and drive MISO low.
- R13: Bytes shift MSB first. MISO changes only after falling SCK edges, and is 0 while select is high. Raising select in the middle of a byte discards that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
A received byte becomes visible to the decoder three system clocks after the SCK rising edge. The response byte is ready one clock later and reaches MISO three clocks after the next falling edge. The bench therefore holds each SCK phase for four clocks and samples MISO just before raising SCK. Program writes land one clock after the decoder sees each byte, so every program is complete before select rises. Erases sweep one byte per clock. After raising select the bench waits the array (or sector) size plus a margin before it reads anything back. Expected bytes come from an array in the bench that applies the requirements: AND-merge, page wrap, sector masks and latch gating.

// File: rtl/flash_pkg.sv
package flash_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_IDENT  = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;
    localparam logic [BYTE_W-1:0] OP_PROG   = 8'h02;
    localparam logic [BYTE_W-1:0] OP_WREN   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_SECT   = 8'hD8;
    localparam logic [BYTE_W-1:0] OP_BULK   = 8'hC7;
    localparam logic [BYTE_W-1:0] OP_ADDR4  = 8'hB7;
    localparam logic [BYTE_W-1:0] OP_RSTEN  = 8'h66;
    localparam logic [BYTE_W-1:0] OP_RSTGO  = 8'h99;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ID,
        S_READ,
        S_PROG,
        S_DISCARD
    } cmd_state_t;
endpackage

// File: rtl/flash_spi_port.sv
module flash_spi_port
    import flash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_pin,
    input  logic              csn_pin,
    input  logic              mosi_pin,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              cs_low,
    output logic              cs_rise,
    output logic              miso
);
    localparam int CW = $clog2(BYTE_W);

    logic [2:0]        sck_s;
    logic [2:0]        csn_s;
    logic [1:0]        mosi_s;
    logic [CW-1:0]     bitcnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              sck_rise;
    logic              sck_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s  <= '0;
            csn_s  <= '1;
            mosi_s <= '0;
        end else begin
            sck_s  <= {sck_s[1:0], sck_pin};
            csn_s  <= {csn_s[1:0], csn_pin};
            mosi_s <= {mosi_s[0], mosi_pin};
        end
    end

    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign sck_fall = ~sck_s[1] & sck_s[2];
    assign cs_low   = ~csn_s[1];
    assign cs_rise  = csn_s[1] & ~csn_s[2];
    assign miso     = tx_sh[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_sh    <= '0;
        end else if (!cs_low) begin
            bitcnt   <= '0;
            rx_valid <= 1'b0;
            tx_sh    <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sck_rise) begin
                rx_sh  <= {rx_sh[BYTE_W-2:0], mosi_s[1]};
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == CW'(BYTE_W - 1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh[BYTE_W-2:0], mosi_s[1]};
                end
            end
            if (sck_fall) begin
                if (bitcnt == '0) tx_sh <= tx_byte;
                else              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // R13
    idle_miso_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> !miso);

    // R13
    byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low && sck_rise && bitcnt == CW'(BYTE_W - 1)) |=> rx_valid);
endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              er_start,
    input  logic [AW-1:0]     er_base,
    input  logic [AW:0]       er_len
);
    localparam logic [AW:0] MEM_LEN = (AW+1)'(MEM_BYTES);

    logic [BYTE_W-1:0] mem [MEM_BYTES];
    logic              er_active;
    logic [AW:0]       er_ptr;
    logic [AW:0]       er_end;

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
            er_active <= 1'b0;
            er_ptr    <= '0;
            er_end    <= '0;
        end else begin
            if (wr_en) mem[wr_addr] <= mem[wr_addr] & wr_data;
            if (er_start) begin
                er_active <= 1'b1;
                er_ptr    <= {1'b0, er_base};
                er_end    <= {1'b0, er_base} + er_len;
            end else if (er_active) begin
                mem[er_ptr[AW-1:0]] <= '1;
                er_ptr <= er_ptr + 1'b1;
                if (er_ptr + 1'b1 == er_end) er_active <= 1'b0;
            end
        end
    end

    // R7 R8
    erase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        er_active |-> (er_ptr < er_end && er_end <= MEM_LEN));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_pkg::*;
#(
    parameter logic [23:0] ID_CODE      = 24'h20BA19,
    parameter int          MEM_BYTES    = 2048,
    parameter int          PAGE_BYTES   = 256,
    parameter int          SECTOR_BYTES = 512,
    parameter int          AW           = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              cs_rise,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              er_start,
    output logic [AW-1:0]     er_base,
    output logic [AW:0]       er_len
);
    localparam int          PW       = $clog2(PAGE_BYTES);
    localparam int          SW       = $clog2(SECTOR_BYTES);
    localparam logic [AW:0] SECT_LEN = (AW+1)'(SECTOR_BYTES);
    localparam logic [AW:0] MEM_LEN  = (AW+1)'(MEM_BYTES);

    cmd_state_t        state, state_nx;
    logic [BYTE_W-1:0] cmd;
    logic [1:0]        abytes;
    logic [AW-9:0]     addr_sh;
    logic [AW-1:0]     addr_full;
    logic              addr_last;
    logic [AW-1:0]     ptr;
    logic [1:0]        id_idx;
    logic              wel;
    logic              four_b;
    logic              rst_arm;
    logic              prog_pend;

    assign addr_full = {addr_sh, rx_byte};
    assign addr_last = (abytes == (four_b ? 2'd3 : 2'd2));
    assign rd_addr   = (state == S_ADDR) ? addr_full : ptr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        if (!cs_low) begin
            state_nx = S_IDLE;
        end else if (rx_valid) begin
            unique case (state)
                S_IDLE: begin
                    case (rx_byte)
                        OP_IDENT: state_nx = S_ID;
                        OP_READ:  state_nx = S_ADDR;
                        OP_SECT:  state_nx = S_ADDR;
                        OP_PROG:  state_nx = wel ? S_ADDR : S_DISCARD;
                        OP_WREN, OP_ADDR4, OP_BULK, OP_RSTEN, OP_RSTGO:
                                  state_nx = S_IDLE;
                        default:  state_nx = S_DISCARD;
                    endcase
                end
                S_ADDR: begin
                    if (addr_last) begin
                        if (cmd == OP_READ)      state_nx = S_READ;
                        else if (cmd == OP_PROG) state_nx = S_PROG;
                        else                     state_nx = S_IDLE;
                    end
                end
                S_ID:      state_nx = S_ID;
                S_READ:    state_nx = S_READ;
                S_PROG:    state_nx = S_PROG;
                S_DISCARD: state_nx = S_DISCARD;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd       <= '0;
            abytes    <= '0;
            addr_sh   <= '0;
            ptr       <= '0;
            id_idx    <= '0;
            wel       <= 1'b0;
            four_b    <= 1'b0;
            rst_arm   <= 1'b0;
            prog_pend <= 1'b0;
            tx_byte   <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            er_start  <= 1'b0;
            er_base   <= '0;
            er_len    <= '0;
        end else begin
            wr_en    <= 1'b0;
            er_start <= 1'b0;
            if (!cs_low) begin
                if (cs_rise && prog_pend) wel <= 1'b0;
                prog_pend <= 1'b0;
                tx_byte   <= '0;
            end else if (rx_valid) begin
                unique case (state)
                    S_IDLE: begin
                        cmd     <= rx_byte;
                        abytes  <= '0;
                        tx_byte <= '0;
                        if (rx_byte != OP_RSTEN) rst_arm <= 1'b0;
                        case (rx_byte)
                            OP_IDENT: begin
                                tx_byte <= ID_CODE[23:16];
                                id_idx  <= 2'd1;
                            end
                            OP_WREN:  wel    <= 1'b1;
                            OP_ADDR4: four_b <= 1'b1;
                            OP_RSTEN: rst_arm <= 1'b1;
                            OP_RSTGO: begin
                                if (rst_arm) begin
                                    four_b <= 1'b0;
                                    wel    <= 1'b0;
                                end
                            end
                            OP_BULK: begin
                                if (wel) begin
                                    er_start <= 1'b1;
                                    er_base  <= '0;
                                    er_len   <= MEM_LEN;
                                    wel      <= 1'b0;
                                end
                            end
                            OP_PROG: begin
                                if (wel) prog_pend <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    S_ADDR: begin
                        addr_sh <= addr_full[AW-9:0];
                        abytes  <= abytes + 1'b1;
                        if (addr_last) begin
                            if (cmd == OP_READ) begin
                                tx_byte <= rd_data;
                                ptr     <= addr_full + 1'b1;
                            end else if (cmd == OP_PROG) begin
                                ptr <= addr_full;
                            end else if (wel) begin
                                er_start <= 1'b1;
                                er_base  <= {addr_full[AW-1:SW], {SW{1'b0}}};
                                er_len   <= SECT_LEN;
                                wel      <= 1'b0;
                            end
                        end
                    end
                    S_ID: begin
                        if (id_idx == 2'd1)      tx_byte <= ID_CODE[15:8];
                        else if (id_idx == 2'd2) tx_byte <= ID_CODE[7:0];
                        else                     tx_byte <= '0;
                        if (id_idx != 2'd3) id_idx <= id_idx + 1'b1;
                    end
                    S_READ: begin
                        tx_byte <= rd_data;
                        ptr     <= ptr + 1'b1;
                    end
                    S_PROG: begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= rx_byte;
                        ptr     <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                    end
                    S_DISCARD: tx_byte <= '0;
                endcase
            end
        end
    end

    // R4
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(rx_valid && state == S_IDLE && rx_byte == OP_WREN));

    // R6
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && prog_pend) |=> !wel);

    // R10
    addr_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(four_b) |-> $past(rx_valid && rx_byte == OP_RSTGO && rst_arm));

    // R12
    discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DISCARD && rx_valid) |=> (tx_byte == '0 && !wr_en && !er_start));
endmodule

// File: rtl/nor_flash_model.sv
module nor_flash_model
    import flash_pkg::*;
#(
    parameter logic [23:0] ID_CODE      = 24'h20BA19,
    parameter int          MEM_BYTES    = 2048,
    parameter int          PAGE_BYTES   = 256,
    parameter int          SECTOR_BYTES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW = $clog2(MEM_BYTES);

    logic [BYTE_W-1:0] tx_byte, rx_byte, rd_data, wr_data;
    logic              rx_valid, cs_low, cs_rise, wr_en, er_start;
    logic [AW-1:0]     rd_addr, wr_addr, er_base;
    logic [AW:0]       er_len;

    flash_spi_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_pin  (spi_sck),
        .csn_pin  (spi_cs_n),
        .mosi_pin (spi_mosi),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .cs_low   (cs_low),
        .cs_rise  (cs_rise),
        .miso     (spi_miso)
    );

    flash_cmd_ctrl #(
        .ID_CODE      (ID_CODE),
        .MEM_BYTES    (MEM_BYTES),
        .PAGE_BYTES   (PAGE_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .AW           (AW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (cs_low),
        .cs_rise  (cs_rise),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_byte  (tx_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .er_start (er_start),
        .er_base  (er_base),
        .er_len   (er_len)
    );

    flash_store #(
        .MEM_BYTES (MEM_BYTES),
        .AW        (AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .er_start (er_start),
        .er_base  (er_base),
        .er_len   (er_len)
    );
endmodule

// File: tb/nor_flash_model_tb_top.sv
`timescale 1ns/1ps
module nor_flash_model_tb_top;
    localparam int MEM  = 2048;
    localparam int PAGE = 256;
    localparam int SECT = 512;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int fails = 0;
    logic [7:0] model [MEM];

    always #2.5 clk = ~clk;

    nor_flash_model dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (sck),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            repeat (HALF) @(negedge clk);
            i[b] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] o);
        logic [7:0] d;
        xfer(o, d);
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic send_addr(input logic [31:0] a, input bit four);
        if (four) send(a[31:24]);
        send(a[23:16]);
        send(a[15:8]);
        send(a[7:0]);
    endtask

    task automatic read_chk(input logic [31:0] a, input int n, input bit four, input string tag);
        logic [7:0] v;
        cs_on();
        send(8'h03);
        send_addr(a, four);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, v);
            check8(tag, v, model[(int'(a[10:0]) + i) % MEM]);
        end
        cs_off();
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_on();
        send(op);
        cs_off();
    endtask

    // program frame; model updated when the bench expects the latch set
    task automatic prog(input int a, input bit four, input int n, input int d0,
                        input int step, input bit ok);
        cs_on();
        send(8'h02);
        send_addr(32'(a), four);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            int idx;
            d = 8'(d0 + i * step);
            send(d);
            idx = ((a % MEM) & ~(PAGE - 1)) | ((a + i) % PAGE);
            if (ok) model[idx] = model[idx] & d;
        end
        cs_off();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired before the run completed");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R13: MISO low while idle
        check8("R13 idle", miso, 1'b0);

        // R1: identification
        cs_on();
        send(8'h9F);
        xfer(8'h00, v); check8("R1 id2", v, 8'h20);
        xfer(8'h00, v); check8("R1 id1", v, 8'hBA);
        xfer(8'h00, v); check8("R1 id0", v, 8'h19);
        xfer(8'h00, v); check8("R1 tail", v, 8'h00);
        cs_off();
        check8("R13 after frame", miso, 1'b0);

        // R2: power-on contents, wrap across the end
        read_chk(32'h000000, 16, 1'b0, "R2");
        read_chk(32'h0007F8, 16, 1'b0, "R2");

        // R13: partial byte then abort
        cs_on();
        for (int b = 0; b < 3; b++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        cs_off();
        cs_on();
        send(8'h9F);
        xfer(8'h00, v); check8("R13 realign", v, 8'h20);
        cs_off();

        // R4: bulk erase without latch
        cmd1(8'hC7);
        repeat (MEM + 20) @(negedge clk);
        read_chk(32'h000040, 8, 1'b0, "R4");

        // R8: bulk erase
        cmd1(8'h06);
        cmd1(8'hC7);
        repeat (MEM + 20) @(negedge clk);
        for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
        read_chk(32'h000000, 256, 1'b0, "R8");
        read_chk(32'h0007F0, 32, 1'b0, "R8");

        // R4: program without latch
        prog(32'h100, 1'b0, 4, 0, 0, 1'b0);
        read_chk(32'h000100, 4, 1'b0, "R4");

        // R5: page wrap
        cmd1(8'h06);
        prog(32'h1FC, 1'b0, 8, 8'h5A, 8'h11, 1'b1);
        read_chk(32'h0001F8, 16, 1'b0, "R5");
        read_chk(32'h000100, 8, 1'b0, "R5");

        // R6: latch cleared by completed program
        prog(32'h180, 1'b0, 2, 0, 0, 1'b0);
        read_chk(32'h000180, 2, 1'b0, "R6");

        // R5: AND merge
        cmd1(8'h06);
        prog(32'h1FC, 1'b0, 1, 8'h0F, 0, 1'b1);
        read_chk(32'h0001FC, 2, 1'b0, "R5");

        cmd1(8'h06);
        prog(32'h200, 1'b0, 4, 8'h11, 8'h11, 1'b1);

        // R5: full page sweep
        cmd1(8'h06);
        prog(32'h300, 1'b0, 256, 3, 7, 1'b1);
        read_chk(32'h000300, 256, 1'b0, "R5");

        // R4: sector erase without latch
        cs_on(); send(8'hD8); send_addr(32'h000050, 1'b0); cs_off();
        repeat (SECT + 20) @(negedge clk);
        read_chk(32'h000100, 4, 1'b0, "R4");

        // R7: sector erase
        cmd1(8'h06);
        cs_on(); send(8'hD8); send_addr(32'h0001A0, 1'b0); cs_off();
        repeat (SECT + 20) @(negedge clk);
        for (int i = 0; i < SECT; i++) model[i] = 8'hFF;
        read_chk(32'h0001F8, 16, 1'b0, "R7");
        read_chk(32'h000100, 8, 1'b0, "R7");

        // R6: latch cleared by erase launch
        cs_on(); send(8'hD8); send_addr(32'h000200, 1'b0); cs_off();
        repeat (SECT + 20) @(negedge clk);
        read_chk(32'h000200, 4, 1'b0, "R6");

        // R11 R9: several commands in one frame, 4-byte address
        cs_on();
        send(8'h06);
        send(8'hB7);
        send(8'h02);
        send_addr(32'hABCD0400, 1'b1);
        send(8'h12); send(8'h34); send(8'h56);
        cs_off();
        model[12'h400] = model[12'h400] & 8'h12;
        model[12'h401] = model[12'h401] & 8'h34;
        model[12'h402] = model[12'h402] & 8'h56;
        read_chk(32'h00000400, 4, 1'b1, "R9 R11");

        // R10: reset sequence restores 3-byte mode
        cs_on(); send(8'h66); send(8'h99); cs_off();
        read_chk(32'h000400, 3, 1'b0, "R10");

        // R10: 0x99 not directly after 0x66 has no effect
        cmd1(8'hB7);
        cs_on(); send(8'h66); send(8'h06); send(8'h99); cs_off();
        prog(32'h401, 1'b1, 1, 8'h0F, 0, 1'b1);
        read_chk(32'h00000400, 3, 1'b1, "R10");

        // R10: reset clears latch
        cmd1(8'h06);
        cs_on(); send(8'h66); send(8'h99); cs_off();
        prog(32'h402, 1'b0, 1, 0, 0, 1'b0);
        read_chk(32'h000402, 1, 1'b0, "R10");

        // R12: unknown opcode discards frame
        cs_on();
        send(8'hAB);
        xfer(8'h06, v); check8("R12 quiet", v, 8'h00);
        xfer(8'h03, v); check8("R12 quiet", v, 8'h00);
        xfer(8'h00, v); check8("R12 quiet", v, 8'h00);
        cs_off();
        prog(32'h500, 1'b0, 1, 0, 0, 1'b0);
        read_chk(32'h000500, 1, 1'b0, "R12");

        // R3: wrap at array end and upper address bits ignored
        cmd1(8'h06);
        prog(32'h7FF, 1'b0, 1, 8'hA5, 0, 1'b1);
        cmd1(8'h06);
        prog(32'h000, 1'b0, 1, 8'h5C, 0, 1'b1);
        read_chk(32'h0007FE, 4, 1'b0, "R3");
        read_chk(32'h00F300, 8, 1'b0, "R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule